// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block brings four supply rails up one at a time and takes them down again in the opposite order. The rails are core (bit 0), I/O (bit 1), charge pump (bit 2) and management (bit 3). It watches an input-valid line and, for each rail, an under-voltage comparator flag and a power-good comparator flag. From these it drives one enable per rail, a global READY flag, a sticky power-fail flag and a 3-bit state code for the host.

All waiting is measured in ticks of an internal free-running prescaler, which pulses every `TICK_DIV` clock cycles. Three lengths are given as tick counts on configuration inputs: the per-rail ramp timeout, the under-voltage blanking interval and the power-good deglitch length. The integration normally ties these to 1000, 200 and 16.

A rail counts as up once its blanking interval has run out and its power-good flag is high. A rail that misses its ramp timeout, or an under-voltage flag on any enabled rail after blanking, starts a fault action. The fault action sheds the rails from the top down. The sequencer then retries a limited number of times and finally latches off. A drop of input-valid at any point of a sequence forces an ordered power-down and sets the power-fail flag.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, `state_code` is 0 (idle), `rail_en` is 0 and `ready` and `pwr_fail` are low. The idle state is left only when `start` and `vin_ok` are both high at a clock edge, and `start` in any other state has no effect.
- R2: Rails turn on strictly in the order bit 0, 1, 2, 3, so `rail_en` is always one of 0000, 0001, 0011, 0111, 1111. The next rail is enabled at the first edge where the current rail has spent more than `cfg_blank` ticks enabled with its `pg` bit high. Once bit 3 qualifies, the state becomes Normal (code 2).
- R3: If the rail being ramped has not qualified when its tick count reaches `cfg_ramp_to`, the sequencer enters Fault-action (code 3) at the next edge.
- R4: While the current rail's tick count is below `cfg_blank`, `uv` is ignored. Outside that window, a `uv` bit of any enabled rail sends the sequencer to Fault-action.
- R5: In Fault-action, one enable is cleared per tick, highest first, and no enable ever rises. Once all are off, the sequencer goes to Retry (code 4) while retries remain (`MAX_RETRY` per start), otherwise to Latched (code 5). Latched keeps all rails off.
- R6: Retry holds all rails off for `cfg_ramp_to` ticks, then restarts the ramp from the core rail (code 1, `rail_en`=0001).
- R7: In Normal, `ready` rises only after all `pg` bits have been high for `cfg_dglt` consecutive ticks. `ready` is never high outside Normal or while any `pg` bit is low.
- R8: `ready` falls in the same cycle that any `pg` bit falls, without deglitch. The state stays Normal and re-qualification restarts.
- R9: A low `vin_ok` in any state other than idle sets `pwr_fail` and enters Power-down (code 6). Power-down clears one enable per tick, highest first, and then returns to idle. `pwr_fail` stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ramp_to | input | CNT_W | Ramp timeout and retry cooldown, in ticks |
| cfg_blank | input | CNT_W | Under-voltage blanking per rail, in ticks |
| cfg_dglt | input | CNT_W | Power-good deglitch length, in ticks |
| vin_ok | input | 1 | Input supply valid |
| start | input | 1 | Synchronous power-up request |
| uv | input | NRAIL | Per-rail under-voltage comparator flags |
| pg | input | NRAIL | Per-rail power-good comparator flags |
| rail_en | output | NRAIL | Per-rail enables, bit 0 = core |
| ready | output | 1 | All rails up and deglitched |
| pwr_fail | output | 1 | Sticky input-loss flag |
| state_code | output | 3 | 0 idle, 1 ramp, 2 normal, 3 fault-action, 4 retry, 5 latched, 6 power-down |

## Verification
With one tick per cycle and a blanking count B, each following rail enable is due B+1 cycles after the one before it. A timeout is due `cfg_ramp_to`+1 cycles after the rail's enable. Shedding proceeds one bit per cycle, and the state change that follows is due one cycle after the mask reaches zero. `ready` is due `cfg_dglt` cycles after Normal is entered or after power-good is restored, and it falls with no delay. The bench pushes each expected output, stamped with the exact cycle in which it is due, into a queue when it applies a stimulus. A monitor samples just after every rising edge and compares whatever is due in that cycle. The combinational fall of `ready` is checked one time step after the stimulus, within the same cycle.

// File: rtl/seq_pkg.sv
// Shared definitions for the rail sequencer.
// Assumes a 3-bit state code is visible to the host; the encoding is fixed.
package seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RAMP   = 3'd1,
        ST_NORMAL = 3'd2,
        ST_FAULT  = 3'd3,
        ST_RETRY  = 3'd4,
        ST_LATCH  = 3'd5,
        ST_PDOWN  = 3'd6
    } seq_state_e;
endpackage

// File: rtl/seq_tick_gen.sv
// Free-running prescaler: pulses tick once every DIV clock cycles.
// Assumes DIV >= 1; DIV = 1 gives a tick on every cycle.
module seq_tick_gen #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Wrap the divider counter at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Tick on the final count of each period.
    always_comb tick = (cnt_q == LAST);
endmodule

// File: rtl/seq_tick_counter.sv
// Saturating tick counter with synchronous clear (clear wins over count).
// Assumes the consumer only compares against thresholds below the saturation value.
module seq_tick_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    // Count ticks, stick at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           cnt <= '0;
        else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_pg_filter.sv
// Power-good deglitch: ok goes high after len ticks of pg_all held high while enabled.
// Falling is immediate: ok is gated combinationally by pg_all and enable.
module seq_pg_filter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         tick,
    input  logic         pg_all,
    input  logic [W-1:0] len,
    output logic         ok
);
    logic [W-1:0] cnt_q;

    // Accumulate qualified ticks; any dropout restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !(enable && pg_all)) cnt_q <= '0;
        else if (tick && cnt_q < len)      cnt_q <= cnt_q + 1'b1;
    end

    // Qualified only while the condition still holds.
    always_comb ok = enable && pg_all && (cnt_q >= len);
endmodule

// File: rtl/rail_seq_top.sv
// Multi-rail power sequencer. Rails turn on from bit 0 upward, each qualified by
// blanking and power-good; faults and input loss shed rails from the top down.
// Assumes uv/pg are already synchronous to clk and rail_en is a low-contiguous mask.
module rail_seq_top
    import seq_pkg::*;
#(
    parameter int unsigned NRAIL     = 4,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned TICK_DIV  = 100,
    parameter int unsigned MAX_RETRY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_ramp_to,
    input  logic [CNT_W-1:0] cfg_blank,
    input  logic [CNT_W-1:0] cfg_dglt,
    input  logic             vin_ok,
    input  logic             start,
    input  logic [NRAIL-1:0] uv,
    input  logic [NRAIL-1:0] pg,
    output logic [NRAIL-1:0] rail_en,
    output logic             ready,
    output logic             pwr_fail,
    output logic [2:0]       state_code
);
    localparam int unsigned IDX_W = (NRAIL > 1) ? $clog2(NRAIL) : 1;
    localparam int unsigned RTY_W = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NRAIL - 1);
    localparam logic [RTY_W-1:0] RTY_LIM  = RTY_W'(MAX_RETRY);
    localparam logic [NRAIL-1:0] FIRST_EN = {{(NRAIL-1){1'b0}}, 1'b1};

    seq_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [NRAIL-1:0] en_q, en_d;
    logic [RTY_W-1:0] rty_q, rty_d;
    logic             pf_q, pf_d;
    logic             tmr_clr;
    logic             tick;
    logic [CNT_W-1:0] t_cnt;
    logic             in_normal, pg_ok;
    logic             blank_done, uv_hit, rail_ok, tmo;

    seq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    seq_tick_counter #(.W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick),
        .cnt   (t_cnt)
    );

    seq_pg_filter #(.W(CNT_W)) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (in_normal),
        .tick   (tick),
        .pg_all (&pg),
        .len    (cfg_dglt),
        .ok     (pg_ok)
    );

    // Per-rail qualification terms for the rail currently ramping.
    always_comb begin
        in_normal  = (st_q == ST_NORMAL);
        blank_done = (t_cnt >= cfg_blank);
        uv_hit     = |(uv & en_q);
        rail_ok    = blank_done && pg[idx_q];
        tmo        = (t_cnt >= cfg_ramp_to);
    end

    // Next-state logic: input loss first, then the per-state rules.
    always_comb begin
        st_d    = st_q;
        idx_d   = idx_q;
        en_d    = en_q;
        rty_d   = rty_q;
        pf_d    = pf_q;
        tmr_clr = 1'b0;
        if (st_q != ST_IDLE && st_q != ST_PDOWN && !vin_ok) begin
            st_d = ST_PDOWN;
            pf_d = 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start && vin_ok) begin
                        st_d    = ST_RAMP;
                        idx_d   = '0;
                        en_d    = FIRST_EN;
                        rty_d   = '0;
                        pf_d    = 1'b0;
                        tmr_clr = 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (blank_done && uv_hit) begin
                        st_d = ST_FAULT;
                    end else if (rail_ok) begin
                        tmr_clr = 1'b1;
                        if (idx_q == LAST_IDX) begin
                            st_d = ST_NORMAL;
                        end else begin
                            idx_d = idx_q + 1'b1;
                            en_d  = {en_q[NRAIL-2:0], 1'b1};
                        end
                    end else if (tmo) begin
                        st_d = ST_FAULT;
                    end
                end
                ST_NORMAL: begin
                    if (uv_hit) st_d = ST_FAULT;
                end
                ST_FAULT: begin
                    if (tick) begin
                        if (en_q == '0) begin
                            if (rty_q < RTY_LIM) begin
                                st_d    = ST_RETRY;
                                rty_d   = rty_q + 1'b1;
                                tmr_clr = 1'b1;
                            end else begin
                                st_d = ST_LATCH;
                            end
                        end else begin
                            en_d = en_q >> 1;
                        end
                    end
                end
                ST_RETRY: begin
                    if (tmo) begin
                        st_d    = ST_RAMP;
                        idx_d   = '0;
                        en_d    = FIRST_EN;
                        tmr_clr = 1'b1;
                    end
                end
                ST_PDOWN: begin
                    if (tick) begin
                        if (en_q == '0) st_d = ST_IDLE;
                        else            en_d = en_q >> 1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            en_q  <= '0;
            rty_q <= '0;
            pf_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            en_q  <= en_d;
            rty_q <= rty_d;
            pf_q  <= pf_d;
        end
    end

    // Outputs; ready follows pg down combinationally through the filter.
    always_comb begin
        rail_en    = en_q;
        ready      = in_normal && pg_ok;
        pwr_fail   = pf_q;
        state_code = st_q;
    end
endmodule

// File: rtl/rail_seq_chk.sv
// Property checker for rail_seq_top, observing ports only; attached by bind below.
module rail_seq_chk
    import seq_pkg::*;
#(
    parameter int unsigned NRAIL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vin_ok,
    input logic             start,
    input logic [NRAIL-1:0] pg,
    input logic [NRAIL-1:0] rail_en,
    input logic             ready,
    input logic             pwr_fail,
    input logic [2:0]       state_code
);
    // R1: idle keeps every rail off.
    assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_IDLE) |-> (rail_en == '0));

    // R1: idle is left only on start with valid input.
    assert_stay_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_IDLE && !(start && vin_ok)) |=> (state_code == ST_IDLE));

    // R2: enables always form a low-contiguous mask.
    assert_contig_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_en & (rail_en + 1'b1)) == '0));

    // R5: shedding never raises an enable.
    assert_shed_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_FAULT) |=> ((rail_en & ~$past(rail_en)) == '0));

    // R5: latched holds all rails off.
    assert_latch_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_LATCH) |-> (rail_en == '0));

    // R6: retry cooldown holds all rails off.
    assert_retry_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_RETRY) |-> (rail_en == '0));

    // R7: ready implies normal state and every power-good high.
    assert_ready_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((&pg) && state_code == ST_NORMAL));

    // R9: input loss during a sequence raises the power-fail flag.
    assert_vin_loss_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vin_ok) && state_code != ST_IDLE) |=> pwr_fail);
endmodule

bind rail_seq_top rail_seq_chk #(.NRAIL(NRAIL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vin_ok     (vin_ok),
    .start      (start),
    .pg         (pg),
    .rail_en    (rail_en),
    .ready      (ready),
    .pwr_fail   (pwr_fail),
    .state_code (state_code)
);

// File: tb/rail_seq_top_tb_top.sv
// Scoreboard bench: stimulus tasks queue cycle-stamped expectations, a monitor compares them.
module rail_seq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        vin_ok = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  pg_block = 4'b0;
    logic [3:0]  uv = 4'b0;
    logic [3:0]  pg;
    logic [3:0]  rail_en;
    logic        ready, pwr_fail;
    logic [2:0]  state_code;

    // Rail model: a rail reports power-good whenever enabled unless blocked.
    assign pg = rail_en & ~pg_block;

    rail_seq_top #(.NRAIL(4), .CNT_W(16), .TICK_DIV(1), .MAX_RETRY(1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ramp_to (16'd12),
        .cfg_blank   (16'd3),
        .cfg_dglt    (16'd4),
        .vin_ok      (vin_ok),
        .start       (start),
        .uv          (uv),
        .pg          (pg),
        .rail_en     (rail_en),
        .ready       (ready),
        .pwr_fail    (pwr_fail),
        .state_code  (state_code)
    );

    typedef struct {
        int         cyc;
        logic [3:0] en;
        logic [2:0] st;
        logic       rdy;
        logic       pf;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic expect_at(int off, logic [3:0] en, logic [2:0] st, logic rdy, logic pf, string tag);
        exp_t e;
        e.cyc = cyc + off; e.en = en; e.st = st; e.rdy = rdy; e.pf = pf; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_now(logic got, logic exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: sample just after each rising edge, compare items due now.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (e.cyc != cyc || rail_en !== e.en || state_code !== e.st ||
                    ready !== e.rdy || pwr_fail !== e.pf) begin
                    n_bad++;
                    $display("FAIL %s: cyc=%0d got en=%b st=%0d rdy=%b pf=%b exp en=%b st=%0d rdy=%b pf=%b",
                             e.tag, cyc, rail_en, state_code, ready, pwr_fail,
                             e.en, e.st, e.rdy, e.pf);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        wait (cyc >= 20000);
        n_bad++;
        $display("FAIL watchdog: cyc=%0d exp finish before 20000", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(1, 4'b0000, 3'd0, 1'b0, 1'b0, "R1 reset state");
        drain();

        // R1: start without valid input is ignored.
        start = 1'b1;
        expect_at(1, 4'b0000, 3'd0, 1'b0, 1'b0, "R1 start without vin");
        @(negedge clk); start = 1'b0;
        drain();

        // R2/R7: full power-up, blank=3 so each rail follows 4 cycles later.
        vin_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        expect_at(1,  4'b0001, 3'd1, 1'b0, 1'b0, "R1 start accepted");
        expect_at(4,  4'b0001, 3'd1, 1'b0, 1'b0, "R2 core held in blanking");
        expect_at(5,  4'b0011, 3'd1, 1'b0, 1'b0, "R2 io enabled");
        expect_at(9,  4'b0111, 3'd1, 1'b0, 1'b0, "R2 pump enabled");
        expect_at(13, 4'b1111, 3'd1, 1'b0, 1'b0, "R2 mgmt enabled");
        expect_at(17, 4'b1111, 3'd2, 1'b0, 1'b0, "R7 normal not yet ready");
        expect_at(20, 4'b1111, 3'd2, 1'b0, 1'b0, "R7 deglitch pending");
        expect_at(21, 4'b1111, 3'd2, 1'b1, 1'b0, "R7 ready after deglitch");
        @(negedge clk); start = 1'b0;
        drain();

        // R8: power-good drop takes ready down at once.
        pg_block = 4'b0100;
        #1 check_now(ready, 1'b0, "R8 ready falls same cycle");
        expect_at(1, 4'b1111, 3'd2, 1'b0, 1'b0, "R8 stays normal");
        @(negedge clk);
        pg_block = 4'b0000;
        expect_at(3, 4'b1111, 3'd2, 1'b0, 1'b0, "R7 requalify pending");
        expect_at(4, 4'b1111, 3'd2, 1'b1, 1'b0, "R7 requalified");
        drain();

        // R1: start outside idle has no effect.
        start = 1'b1;
        expect_at(1, 4'b1111, 3'd2, 1'b1, 1'b0, "R1 start ignored in normal");
        @(negedge clk); start = 1'b0;
        drain();

        // R9: input loss from normal.
        vin_ok = 1'b0;
        expect_at(1, 4'b1111, 3'd6, 1'b0, 1'b1, "R9 power-down entry");
        expect_at(2, 4'b0111, 3'd6, 1'b0, 1'b1, "R9 mgmt off first");
        expect_at(5, 4'b0000, 3'd6, 1'b0, 1'b1, "R9 all off");
        expect_at(6, 4'b0000, 3'd0, 1'b0, 1'b1, "R9 idle with flag held");
        drain();

        // R3/R5/R6: io rail never good; timeout, shed, retry, latch.
        vin_ok = 1'b1;
        pg_block = 4'b0010;
        @(negedge clk);
        start = 1'b1;
        expect_at(1,  4'b0001, 3'd1, 1'b0, 1'b0, "R9 flag cleared on start");
        expect_at(5,  4'b0011, 3'd1, 1'b0, 1'b0, "R2 io enabled");
        expect_at(17, 4'b0011, 3'd1, 1'b0, 1'b0, "R3 before timeout");
        expect_at(18, 4'b0011, 3'd3, 1'b0, 1'b0, "R3 timeout");
        expect_at(19, 4'b0001, 3'd3, 1'b0, 1'b0, "R5 io shed");
        expect_at(20, 4'b0000, 3'd3, 1'b0, 1'b0, "R5 core shed");
        expect_at(21, 4'b0000, 3'd4, 1'b0, 1'b0, "R5 retry entry");
        expect_at(33, 4'b0000, 3'd4, 1'b0, 1'b0, "R6 cooldown");
        expect_at(34, 4'b0001, 3'd1, 1'b0, 1'b0, "R6 restart");
        expect_at(38, 4'b0011, 3'd1, 1'b0, 1'b0, "R2 io again");
        expect_at(51, 4'b0011, 3'd3, 1'b0, 1'b0, "R3 second timeout");
        expect_at(53, 4'b0000, 3'd3, 1'b0, 1'b0, "R5 shed again");
        expect_at(54, 4'b0000, 3'd5, 1'b0, 1'b0, "R5 latched");
        @(negedge clk); start = 1'b0;
        drain();

        start = 1'b1;
        expect_at(1, 4'b0000, 3'd5, 1'b0, 1'b0, "R5 latched ignores start");
        @(negedge clk); start = 1'b0;
        drain();

        vin_ok = 1'b0;
        expect_at(1, 4'b0000, 3'd6, 1'b0, 1'b1, "R9 loss while latched");
        expect_at(2, 4'b0000, 3'd0, 1'b0, 1'b1, "R9 back to idle");
        drain();

        // R4: uv during blanking ignored, uv after blanking faults.
        vin_ok = 1'b1;
        pg_block = 4'b0000;
        @(negedge clk);
        start = 1'b1;
        expect_at(1,  4'b0001, 3'd1, 1'b0, 1'b0, "R1 start accepted");
        expect_at(4,  4'b0001, 3'd1, 1'b0, 1'b0, "R4 uv masked in blanking");
        expect_at(5,  4'b0011, 3'd1, 1'b0, 1'b0, "R4 ramp continues");
        expect_at(17, 4'b1111, 3'd2, 1'b0, 1'b0, "R4 normal reached");
        @(negedge clk); start = 1'b0; uv = 4'b0001;
        @(negedge clk);
        @(negedge clk); uv = 4'b0000;
        drain();
        repeat (6) @(negedge clk);
        uv = 4'b0001;
        expect_at(1,  4'b1111, 3'd3, 1'b0, 1'b0, "R4 uv fault");
        expect_at(2,  4'b0111, 3'd3, 1'b0, 1'b0, "R5 top shed first");
        expect_at(5,  4'b0000, 3'd3, 1'b0, 1'b0, "R5 all shed");
        expect_at(6,  4'b0000, 3'd4, 1'b0, 1'b0, "R5 retry after uv");
        expect_at(19, 4'b0001, 3'd1, 1'b0, 1'b0, "R6 restart from core");
        @(negedge clk); uv = 4'b0000;
        drain();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule